// File: doc/BRIEF.md
# Configurable Parallel-to-Serial Output Serializer

This block turns a parallel word into a serial bit stream on a single fast clock. An internal frame counter stands in for the divided word clock. In the fast cycle that ends with a divided-clock rising edge, the block raises `div_edge_o` and samples `word_i` and the three-state control group `tri_i`. It then sends the word out least significant bit first, at a fixed latency that depends on the rate.

Single-rate mode emits one bit per fast cycle. Double-rate mode emits two bits per fast cycle. Those two bits appear as a slot pair on `dq_o`: slot 0 goes in the first half-period and slot 1 in the second. A pad multiplexer outside the block selects between them with the clock phase, so no logic here runs on the falling edge.

A parallel group of three-state control bits travels alongside the data. Each control bit covers an equal run of consecutive data slots, and a high value means those slots are not driven. In buffer mode the control path instead tracks `tri_i[0]` cycle by cycle.

The data path and the three-state path each have their own clock enable, their own power-up value and their own synchronous-reset value. Word widths above six are handled as one wider internal word, up to ten bits.

Elaboration rejects any width and rate combination outside these sets:
- single-rate data: widths 2 to 8
- double-rate data: even widths 4 to 10
- double-rate control: 2 or 4 bits that divide the width, and only when the data is also double-rate
- single-rate or buffer control: exactly 1 bit

Top module: `par2ser_out`

## Requirements
- R1: Bit 0 of the sampled word is sent first, followed by ascending bit positions. In double-rate mode `dq_o[0]` carries the earlier bit and `dq_o[1]` the later bit. In single-rate mode both slots carry the same bit.
- R2: In single-rate mode, bit 0 of the word sampled at the end of a `div_edge_o` cycle appears on `dq_o` one fast cycle after that edge. The remaining bits follow one per cycle, and consecutive words follow with no gap.
- R3: In double-rate mode, the first slot pair appears WIDTH/2 fast cycles after the sampling edge (4 cycles for an 8-bit word). One pair follows per cycle, with no gap between words.
- R4: `div_edge_o` is high for one cycle in every FRAME cycles, where FRAME is WIDTH in single-rate mode and WIDTH/2 in double-rate mode. It is high in the first cycle after any reset.
- R5: Outside buffer mode, `tq_o` slots (1 = slot not driven) carry the control bits with the same sampling edge, latency and slot order as the data. Control bit k applies to data slots k*WIDTH/TRI_WIDTH through (k+1)*WIDTH/TRI_WIDTH-1.
- R6: In buffer mode, both slots of `tq_o` take `tri_i[0]` one cycle after it is sampled, with no framing.
- R7: While `oce_i` is low, `dq_o` holds its value. The serializer keeps advancing, so the bits of those cycles are dropped.
- R8: While `tce_i` is low, `tq_o` holds its value.
- R9: A cycle with `srst_i` high sets both slots of `dq_o` to SRVAL_DQ and both slots of `tq_o` to SRVAL_TQ, whatever the enables are. It also restarts the frame. The outputs stay at those values until the first bits of a new word arrive.
- R10: `rst_ni` low sets both slots of `dq_o` to INIT_DQ and both slots of `tq_o` to INIT_TQ at once. After release the outputs keep those values until the first new bits arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset to the INIT values |
| srst_i | input | 1 | Synchronous active-high reset to the SRVAL values |
| word_i | input | WIDTH | Parallel data word, sampled in `div_edge_o` cycles |
| tri_i | input | TRI_WIDTH | Parallel three-state control group |
| oce_i | input | 1 | Data output clock enable |
| tce_i | input | 1 | Three-state output clock enable |
| div_edge_o | output | 1 | High in the fast cycle ending with a divided-clock edge |
| dq_o | output | 2 | Serial data slot pair, slot 0 first |
| tq_o | output | 2 | Serial three-state slot pair, 1 = not driven |

## Verification
The bench drives three configurations side by side: an 8-bit double-rate word with four control bits, a 5-bit single-rate word with a buffered control path, and a 2-bit single-rate word. These cover the odd frame length, the shortest frame and the longest latency.

The bench checks the exact cycle of the first bit after every reset. A design one register short or one register long would shift the whole stream by one cycle, and every later slot would compare wrong.

Clock-enable gaps are placed at random. A design that stalled the shifter during a gap, instead of dropping bits, would fall out of frame with `div_edge_o`.

Synchronous resets are applied with the enables low. A design that gated the reset with an enable would keep stale slots, and a design that filled the shifter with zeros would show a dip in `dq_o` before the first word.

// File: rtl/ser_pkg.sv
package ser_pkg;
  typedef enum logic [1:0] {RATE_SDR, RATE_DDR, RATE_BUF} rate_e;

  function automatic int frame_len(int w, rate_e dr);
    return (dr == RATE_DDR) ? w / 2 : w;
  endfunction

  function automatic bit cfg_ok(int w, rate_e dr, rate_e tr, int tw);
    bit d_ok, t_ok;
    d_ok = (dr == RATE_SDR) ? (w >= 2 && w <= 8)
         : (dr == RATE_DDR) ? (w >= 4 && w <= 10 && (w % 2) == 0)
         : 1'b0;
    t_ok = (tr == RATE_DDR) ? (dr == RATE_DDR && (tw == 2 || tw == 4) && (w % tw) == 0)
         : (tw == 1);
    return d_ok && t_ok;
  endfunction
endpackage

// File: rtl/ser_frame_ctr.sv
module ser_frame_ctr #(
  parameter int FRAME = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  output logic cap_o,
  output logic pre_o
);
  localparam int CW = (FRAME > 2) ? $clog2(FRAME) : 1;
  localparam logic [CW-1:0] LAST = CW'(FRAME - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (srst_i)         cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign cap_o = (cnt_q == '0);
  assign pre_o = (cnt_q == LAST);

  assert_frame_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_o && !srst_i) |=> cap_o);
  assert_cap_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_o && !srst_i) |=> !cap_o);
endmodule

// File: rtl/ser_lane.sv
module ser_lane #(
  parameter int W     = 8,
  parameter bit DDR   = 1'b1,
  parameter bit INIT  = 1'b0,
  parameter bit SRVAL = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         srst_i,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  input  logic         ce_i,
  output logic [1:0]   pair_o
);
  localparam int STEP = DDR ? 2 : 1;

  logic [W-1:0] sh_q, sh_d;
  logic [1:0]   pair_d, pair_q;

  // refill from the top bit keeps the reset fill level until the first load
  assign sh_d = load_i ? word_i : {{STEP{sh_q[W-1]}}, sh_q[W-1:STEP]};

  if (DDR) begin : g_ddr
    assign pair_d = {sh_q[1], sh_q[0]};
  end else begin : g_sdr
    assign pair_d = {2{sh_q[0]}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= {W{INIT}};
      pair_q <= {2{INIT}};
    end else if (srst_i) begin
      sh_q   <= {W{SRVAL}};
      pair_q <= {2{SRVAL}};
    end else begin
      sh_q <= sh_d;
      if (ce_i) pair_q <= pair_d;
    end
  end

  assign pair_o = pair_q;

  // R7 on the data lane, R8 on the three-state lane
  assert_out_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && !ce_i) |=> $stable(pair_o));
  assert_srst_value_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (pair_o == {2{SRVAL}}));
endmodule

// File: rtl/par2ser_out.sv
module par2ser_out #(
  parameter int             WIDTH     = 8,
  parameter ser_pkg::rate_e DATA_RATE = ser_pkg::RATE_DDR,
  parameter ser_pkg::rate_e TRI_RATE  = ser_pkg::RATE_DDR,
  parameter int             TRI_WIDTH = 4,
  parameter bit             INIT_DQ   = 1'b0,
  parameter bit             INIT_TQ   = 1'b0,
  parameter bit             SRVAL_DQ  = 1'b0,
  parameter bit             SRVAL_TQ  = 1'b0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 srst_i,
  input  logic [WIDTH-1:0]     word_i,
  input  logic [TRI_WIDTH-1:0] tri_i,
  input  logic                 oce_i,
  input  logic                 tce_i,
  output logic                 div_edge_o,
  output logic [1:0]           dq_o,
  output logic [1:0]           tq_o
);
  import ser_pkg::*;

  localparam bit IS_DDR = (DATA_RATE == RATE_DDR);
  localparam int FRAME  = frame_len(WIDTH, DATA_RATE);
  localparam int SPAN   = (WIDTH / TRI_WIDTH < 1) ? 1 : WIDTH / TRI_WIDTH;

  initial begin
    assert_cfg_legal: assert (cfg_ok(WIDTH, DATA_RATE, TRI_RATE, TRI_WIDTH))
      else $error("par2ser_out: illegal width/rate combination");
  end

  logic cap, pre, load;
  logic [WIDTH-1:0] tri_slots, dq_word, tq_word;

  ser_frame_ctr #(.FRAME(FRAME)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(srst_i), .cap_o(cap), .pre_o(pre)
  );
  assign div_edge_o = cap;

  // spread each control bit over its run of data slots
  for (genvar j = 0; j < WIDTH; j++) begin : g_tx
    localparam int IDX_RAW = j / SPAN;
    localparam int IDX     = (IDX_RAW < TRI_WIDTH) ? IDX_RAW : TRI_WIDTH - 1;
    assign tri_slots[j] = tri_i[IDX];
  end

  if (IS_DDR) begin : g_hold
    // park the word for a frame so the lane loads it just before the next capture
    logic [WIDTH-1:0] dh_q, th_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dh_q <= '0;
        th_q <= '0;
      end else if (srst_i) begin
        dh_q <= '0;
        th_q <= '0;
      end else if (cap) begin
        dh_q <= word_i;
        th_q <= tri_slots;
      end
    end
    assign load    = pre;
    assign dq_word = dh_q;
    assign tq_word = th_q;
  end else begin : g_direct
    assign load    = cap;
    assign dq_word = word_i;
    assign tq_word = tri_slots;
  end

  ser_lane #(.W(WIDTH), .DDR(IS_DDR), .INIT(INIT_DQ), .SRVAL(SRVAL_DQ)) u_dq_lane (
    .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(srst_i), .load_i(load),
    .word_i(dq_word), .ce_i(oce_i), .pair_o(dq_o)
  );

  if (TRI_RATE == RATE_BUF) begin : g_tq_buf
    logic [1:0] tq_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     tq_q <= {2{INIT_TQ}};
      else if (srst_i) tq_q <= {2{SRVAL_TQ}};
      else if (tce_i)  tq_q <= {2{tri_i[0]}};
    end
    assign tq_o = tq_q;

    assert_buf_follow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!srst_i && tce_i) |=> (tq_o == {2{$past(tri_i[0])}}));
  end else begin : g_tq_lane
    ser_lane #(.W(WIDTH), .DDR(IS_DDR), .INIT(INIT_TQ), .SRVAL(SRVAL_TQ)) u_tq_lane (
      .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(srst_i), .load_i(load),
      .word_i(tq_word), .ce_i(tce_i), .pair_o(tq_o)
    );
  end
endmodule

// File: tb/sim_par2ser_out.sv
`timescale 1ns/1ps
module sim_par2ser_out;
  localparam int NCYC = 1600;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, srst = 1'b0, oce = 1'b1, tce = 1'b1;
  logic [9:0] word = '0;
  logic [3:0] tv = '0;
  logic [2:0][1:0] dq, tq;
  logic [2:0] de;

  par2ser_out u0 (
    .clk_i(clk), .rst_ni(rst_n), .srst_i(srst), .word_i(word[7:0]), .tri_i(tv),
    .oce_i(oce), .tce_i(tce), .div_edge_o(de[0]), .dq_o(dq[0]), .tq_o(tq[0])
  );
  par2ser_out #(.WIDTH(5), .DATA_RATE(ser_pkg::RATE_SDR), .TRI_RATE(ser_pkg::RATE_BUF),
    .TRI_WIDTH(1), .INIT_DQ(1'b1), .INIT_TQ(1'b1), .SRVAL_DQ(1'b0), .SRVAL_TQ(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .srst_i(srst), .word_i(word[4:0]), .tri_i(tv[0]),
    .oce_i(oce), .tce_i(tce), .div_edge_o(de[1]), .dq_o(dq[1]), .tq_o(tq[1])
  );
  par2ser_out #(.WIDTH(2), .DATA_RATE(ser_pkg::RATE_SDR), .TRI_RATE(ser_pkg::RATE_SDR),
    .TRI_WIDTH(1), .INIT_DQ(1'b0), .INIT_TQ(1'b0), .SRVAL_DQ(1'b1), .SRVAL_TQ(1'b0)) u2 (
    .clk_i(clk), .rst_ni(rst_n), .srst_i(srst), .word_i(word[1:0]), .tri_i(tv[0]),
    .oce_i(oce), .tce_i(tce), .div_edge_o(de[2]), .dq_o(dq[2]), .tq_o(tq[2])
  );

  int w_p [3]     = '{8, 5, 2};
  bit ddr_p [3]   = '{1'b1, 1'b0, 1'b0};
  int tw_p [3]    = '{4, 1, 1};
  bit tbuf_p [3]  = '{1'b0, 1'b1, 1'b0};
  bit idq_p [3]   = '{1'b0, 1'b1, 1'b0};
  bit itq_p [3]   = '{1'b0, 1'b1, 1'b0};
  bit sdq_p [3]   = '{1'b0, 1'b0, 1'b1};
  bit stq_p [3]   = '{1'b0, 1'b1, 1'b0};

  logic [9:0] wd_a [NCYC];
  logic [3:0] tv_a [NCYC];
  bit oce_a [NCYC], tce_a [NCYC], srst_a [NCYC], arst_a [NCYC];

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(string tag, string what, logic [1:0] act, logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%b exp=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] raw(int i, int r, int base, bit is_tri, logic fill);
    int lat, frame, k, c, j, span;
    logic [9:0] s;
    lat   = ddr_p[i] ? w_p[i] / 2 : 1;
    frame = ddr_p[i] ? w_p[i] / 2 : w_p[i];
    if (r < lat + 1) return {fill, fill};
    k = r - lat - 1;
    c = base + (k / frame) * frame;
    j = k % frame;
    span = w_p[i] / tw_p[i];
    s = '0;
    if (!is_tri) s = wd_a[c];
    else for (int b = 0; b < w_p[i]; b++) s[b] = tv_a[c][b / span];
    return ddr_p[i] ? {s[2*j+1], s[2*j]} : {s[j], s[j]};
  endfunction

  initial begin
    logic [1:0] edq [3];
    logic [1:0] etq [3];
    int base, r, frame;
    bit seg_async;
    string tg;
    base = 0;
    seg_async = 1'b1;
    void'($urandom(32'h5EED0017));
    repeat (3) @(posedge clk);
    for (int n = 0; n < NCYC; n++) begin
      @(negedge clk);
      if (n == 0) begin
        base = 0; seg_async = 1'b1;
      end else if (arst_a[n-1] || srst_a[n-1]) begin
        base = n; seg_async = arst_a[n-1];
      end
      r = n - base;
      for (int i = 0; i < 3; i++) begin
        if (r == 0) begin
          edq[i] = {2{seg_async ? idq_p[i] : sdq_p[i]}};
          etq[i] = {2{seg_async ? itq_p[i] : stq_p[i]}};
        end else begin
          if (oce_a[n-1]) edq[i] = raw(i, r, base, 1'b0, seg_async ? idq_p[i] : sdq_p[i]);
          if (tce_a[n-1])
            etq[i] = tbuf_p[i] ? {2{tv_a[n-1][0]}}
                               : raw(i, r, base, 1'b1, seg_async ? itq_p[i] : stq_p[i]);
        end
        // data tag
        if (r == 0)              tg = seg_async ? "R10" : "R9";
        else if (!oce_a[n-1])    tg = "R7";
        else                     tg = ddr_p[i] ? "R1 R3" : "R1 R2";
        chk(tg, $sformatf("dq u%0d", i), dq[i], edq[i]);
        if (r == 0)              tg = seg_async ? "R10" : "R9";
        else if (!tce_a[n-1])    tg = "R8";
        else                     tg = tbuf_p[i] ? "R6" : "R5";
        chk(tg, $sformatf("tq u%0d", i), tq[i], etq[i]);
        frame = ddr_p[i] ? w_p[i] / 2 : w_p[i];
        chk("R4", $sformatf("div_edge u%0d", i), {1'b0, de[i]}, {1'b0, (r % frame) == 0});
      end
      // directed first-bit checks after power-up
      if (n == 5) chk("R1 R3", "u0 first pair 8:1", dq[0], 2'b01);
      if (n == 2) chk("R1 R2", "u2 first bit 2:1", dq[2], 2'b11);
      if (n == 1) chk("R2", "u2 still init", dq[2], 2'b00);

      // stimulus for cycle n
      wd_a[n]   = (n == 0) ? 10'h001 : 10'($urandom);
      tv_a[n]   = 4'($urandom);
      oce_a[n]  = (n < 400) ? 1'b1 : (($urandom % 4) != 0);
      tce_a[n]  = (n < 400) ? 1'b1 : (($urandom % 4) != 0);
      arst_a[n] = (n == 1300);
      srst_a[n] = !arst_a[n] && ((n >= 900 && n < 903) ||
                  (n >= 1000 && n < 1500 && ($urandom % 150) == 0));
      if (n >= 900 && n < 903) begin
        oce_a[n] = 1'b0;
        tce_a[n] = 1'b0;
      end
      word  = wd_a[n];
      tv    = tv_a[n];
      oce   = oce_a[n];
      tce   = tce_a[n];
      srst  = srst_a[n];
      rst_n = !arst_a[n];
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule